// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This block translates a virtual page number into a physical frame number. The translations live in a small on-chip table organised as hash buckets. Each bucket holds the pointer to the head of a linked collision chain. A lookup hashes the page number to pick a bucket. The engine then walks that bucket's chain one element per clock until one of four things happens: it finds an element with the same page number, it reaches the null pointer, it meets an invalid element, or it hits the hop limit.

Lookups use a valid/ready request channel and a valid/ready response channel. The response carries a hit flag and the frame number. Only one lookup is in flight at a time. A separate write port loads chain elements and bucket heads. Deciding where entries go, and removing them, is left to whatever drives the write port.

Top module: `hpt_lookup`

## Requirements
- R1: During and after reset, with no request accepted, `req_ready` is 1 and `rsp_valid` is 0. All elements are invalid and all bucket heads hold the null pointer.
- R2: The bucket for a page number is the low `BKT_W` bits of the XOR of its upper `VPN_W/2` bits with its lower `VPN_W/2` bits. With the defaults this is `((vpn >> 4) ^ vpn) & 3`.
- R3: When a valid element whose page number equals the request lies on the chain, the response has `rsp_hit` = 1 and the frame number of the first such element in chain order.
- R4: Pointer value 0 is the null pointer. Reaching it, including through a bucket head of 0, ends the walk with a miss.
- R5: Reaching an element whose valid bit is 0 ends the walk with a miss, even when that element's page number equals the request.
- R6: The engine examines one element per clock. `rsp_valid` rises k clock edges after the edge that accepts the request, where k is the number of elements examined. A null pointer counts as one examined element.
- R7: A walk examines at most `MAX_HOPS` elements (default 6). If none of them ends the walk, it ends with a miss after `MAX_HOPS` edges, even on a chain that loops back on itself.
- R8: `req_ready` is 0 from the accepting edge until the edge where a response is taken with `rsp_ready` = 1. While `rsp_valid` = 1 and `rsp_ready` = 0, `rsp_hit` and `rsp_pfn` hold their values.
- R9: On a clock edge with `wr_en` = 1:
  - If `wr_head` = 0, the element at `wr_addr` is loaded from `wr_valid`, `wr_vpn`, `wr_pfn` and `wr_next`. A write to element 0 is ignored.
  - If `wr_head` = 1, the bucket head numbered `wr_addr` is set to `wr_next`. A bucket address of `2**BKT_W` or more is ignored.
- R10: On a miss, `rsp_pfn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_vpn | input | VPN_W | Page number to translate |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 = translation found |
| rsp_pfn | output | PFN_W | Frame number on a hit, 0 on a miss |
| wr_en | input | 1 | Write strobe |
| wr_head | input | 1 | 1 = write a bucket head, 0 = write a chain element |
| wr_addr | input | PTR_W | Element index or bucket index |
| wr_valid | input | 1 | Valid bit of the element written |
| wr_vpn | input | VPN_W | Page number of the element written |
| wr_pfn | input | PFN_W | Frame number of the element written |
| wr_next | input | PTR_W | Next pointer of the element, or the new bucket head |

## Verification
The bench keeps its own copy of the table, built from the writes it issues. For every lookup it walks that copy by the rules above, which gives the expected result and the number k of elements the walk examines. After the accepting edge it counts clock edges, sampling `rsp_valid` on each falling edge. The response must appear on exactly edge k: one edge for a null or invalid head, and `MAX_HOPS` edges for a looped chain. Held-response checks sample one falling edge after a rising edge with `rsp_ready` low. Ready-recovery checks sample on the falling edge that follows the taking edge.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    parameter int VPN_W = 8;
    parameter int PFN_W = 6;
    parameter int PTR_W = 4;
    parameter int BKT_W = 2;

    localparam int HALF_W = VPN_W / 2;
    localparam int N_ENT  = 1 << PTR_W;
    localparam int N_BKT  = 1 << BKT_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [BKT_W-1:0] bkt_t;

    localparam ptr_t NULL_PTR = '0;

    typedef struct packed {
        logic vld;
        vpn_t vpn;
        pfn_t pfn;
        ptr_t nxt;
    } chain_elem_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WALK = 2'd1,
        S_RESP = 2'd2
    } walk_state_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_MISS = 2'd1,
        STEP_HIT  = 2'd2,
        STEP_NEXT = 2'd3
    } step_t;

    // Fold the page number in half with XOR and keep the bucket-width low bits.
    function automatic bkt_t hash_vpn(input vpn_t v);
        logic [HALF_W-1:0] folded;
        folded = v[VPN_W-1 -: HALF_W] ^ v[HALF_W-1:0];
        return folded[BKT_W-1:0];
    endfunction

endpackage

// File: rtl/hpt_bucket_table.sv
module hpt_bucket_table
    import hpt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_head,
    input  ptr_t wr_addr,
    input  ptr_t wr_next,
    input  bkt_t rd_bkt,
    output ptr_t rd_head
);

    ptr_t heads [N_BKT];

    for (genvar b = 0; b < N_BKT; b++) begin : g_head
        always_ff @(posedge clk) begin
            if (rst) begin
                heads[b] <= NULL_PTR;
            end else if (wr_en && wr_head && (wr_addr == PTR_W'(b))) begin
                heads[b] <= wr_next;
            end
        end
    end

    assign rd_head = heads[rd_bkt];

endmodule

// File: rtl/hpt_entry_store.sv
module hpt_entry_store
    import hpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_head,
    input  ptr_t        wr_addr,
    input  chain_elem_t wr_elem,
    input  ptr_t        rd_ptr,
    output chain_elem_t rd_elem
);

    chain_elem_t rows [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_row
        if (g == 0) begin : g_null
            // Slot 0 is the null pointer target and never holds data.
            assign rows[g] = '0;
        end else begin : g_data
            always_ff @(posedge clk) begin
                if (rst) begin
                    rows[g] <= '0;
                end else if (wr_en && !wr_head && (wr_addr == PTR_W'(g))) begin
                    rows[g] <= wr_elem;
                end
            end
        end
    end

    assign rd_elem = rows[rd_ptr];

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int MAX_HOPS = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  vpn_t        req_vpn,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic        rsp_hit,
    output pfn_t        rsp_pfn,
    output bkt_t        head_bkt,
    input  ptr_t        head_ptr,
    output ptr_t        elem_ptr,
    input  chain_elem_t elem
);

    localparam int HOP_W = $clog2(MAX_HOPS + 1);
    localparam logic [HOP_W-1:0] LAST_HOP = HOP_W'(MAX_HOPS - 1);

    walk_state_t      state;
    vpn_t             cur_vpn;
    ptr_t             cur_ptr;
    logic [HOP_W-1:0] hops;
    logic             hit_q;
    pfn_t             pfn_q;
    step_t            step;

    assign head_bkt  = hash_vpn(req_vpn);
    assign elem_ptr  = cur_ptr;
    assign req_ready = (state == S_IDLE);
    assign rsp_valid = (state == S_RESP);
    assign rsp_hit   = hit_q;
    assign rsp_pfn   = pfn_q;

    always_comb begin
        step = STEP_NONE;
        if (state == S_WALK) begin
            if (cur_ptr == NULL_PTR || !elem.vld) begin
                step = STEP_MISS;
            end else if (elem.vpn == cur_vpn) begin
                step = STEP_HIT;
            end else if (hops == LAST_HOP) begin
                step = STEP_MISS;
            end else begin
                step = STEP_NEXT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cur_vpn <= '0;
            cur_ptr <= NULL_PTR;
            hops    <= '0;
            hit_q   <= 1'b0;
            pfn_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_vpn <= req_vpn;
                        cur_ptr <= head_ptr;
                        hops    <= '0;
                        state   <= S_WALK;
                    end
                end
                S_WALK: begin
                    unique case (step)
                        STEP_HIT: begin
                            hit_q <= 1'b1;
                            pfn_q <= elem.pfn;
                            state <= S_RESP;
                        end
                        STEP_MISS: begin
                            hit_q <= 1'b0;
                            pfn_q <= '0;
                            state <= S_RESP;
                        end
                        STEP_NEXT: begin
                            cur_ptr <= elem.nxt;
                            hops    <= hops + 1'b1;
                        end
                        default: ;
                    endcase
                end
                S_RESP: begin
                    if (rsp_ready) begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_hops_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_WALK) |-> (hops < HOP_W'(MAX_HOPS)));

    p_null_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_WALK && cur_ptr == NULL_PTR) |=> (rsp_valid && !rsp_hit));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_hold_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_pfn)));

    p_miss_pfn_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0));

endmodule

// File: rtl/hpt_lookup.sv
module hpt_lookup
    import hpt_pkg::*;
#(
    parameter int MAX_HOPS = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_hit,
    output logic [PFN_W-1:0] rsp_pfn,
    input  logic             wr_en,
    input  logic             wr_head,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic             wr_valid,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [PTR_W-1:0] wr_next
);

    bkt_t        head_bkt;
    ptr_t        head_ptr;
    ptr_t        elem_ptr;
    chain_elem_t elem;
    chain_elem_t wr_elem;

    assign wr_elem = '{vld: wr_valid, vpn: wr_vpn, pfn: wr_pfn, nxt: wr_next};

    hpt_bucket_table u_buckets (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_head (wr_head),
        .wr_addr (wr_addr),
        .wr_next (wr_next),
        .rd_bkt  (head_bkt),
        .rd_head (head_ptr)
    );

    hpt_entry_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_head (wr_head),
        .wr_addr (wr_addr),
        .wr_elem (wr_elem),
        .rd_ptr  (elem_ptr),
        .rd_elem (elem)
    );

    hpt_walker #(.MAX_HOPS(MAX_HOPS)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_vpn   (req_vpn),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_hit   (rsp_hit),
        .rsp_pfn   (rsp_pfn),
        .head_bkt  (head_bkt),
        .head_ptr  (head_ptr),
        .elem_ptr  (elem_ptr),
        .elem      (elem)
    );

endmodule

// File: tb/hpt_lookup_test.sv
module hpt_lookup_test;
    import hpt_pkg::*;

    localparam int MAX_HOPS = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VPN_W-1:0] req_vpn = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b0;
    logic             rsp_hit;
    logic [PFN_W-1:0] rsp_pfn;
    logic             wr_en = 1'b0;
    logic             wr_head = 1'b0;
    logic [PTR_W-1:0] wr_addr = '0;
    logic             wr_valid = 1'b0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic [PFN_W-1:0] wr_pfn = '0;
    logic [PTR_W-1:0] wr_next = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // Mirror of table contents, built only from issued writes.
    bit       m_vld  [N_ENT];
    int       m_vpn  [N_ENT];
    int       m_pfn  [N_ENT];
    int       m_nxt  [N_ENT];
    int       m_head [N_BKT];

    always #4 clk = ~clk;

    hpt_lookup #(.MAX_HOPS(MAX_HOPS)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
        .wr_en(wr_en), .wr_head(wr_head), .wr_addr(wr_addr), .wr_valid(wr_valid),
        .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .wr_next(wr_next)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bucket_of(input int v);
        return ((v >> HALF_W) ^ v) & (N_BKT - 1);
    endfunction

    task automatic put_elem(input int addr, input bit v, input int vpn, input int pfn, input int nxt);
        @(negedge clk);
        wr_en = 1'b1; wr_head = 1'b0; wr_addr = PTR_W'(addr); wr_valid = v;
        wr_vpn = VPN_W'(vpn); wr_pfn = PFN_W'(pfn); wr_next = PTR_W'(nxt);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (addr != 0) begin
            m_vld[addr] = v; m_vpn[addr] = vpn; m_pfn[addr] = pfn; m_nxt[addr] = nxt;
        end
    endtask

    task automatic put_head(input int b, input int ptr);
        @(negedge clk);
        wr_en = 1'b1; wr_head = 1'b1; wr_addr = PTR_W'(b); wr_next = PTR_W'(ptr);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_head = 1'b0;
        if (b < N_BKT) m_head[b] = ptr;
    endtask

    task automatic insert(input int addr, input int vpn, input int pfn);
        int b;
        b = bucket_of(vpn);
        put_elem(addr, 1'b1, vpn, pfn, m_head[b]);
        put_head(b, addr);
    endtask

    // Reference walk over the mirror. reason: 0 hit, 4 null, 5 invalid, 7 hop limit.
    task automatic model(input int v, output bit hit, output int pfn, output int steps, output int reason);
        int p;
        p = m_head[bucket_of(v)];
        steps = 0; hit = 0; pfn = 0; reason = 7;
        for (int i = 0; i < MAX_HOPS; i++) begin
            steps++;
            if (p == 0) begin reason = 4; return; end
            if (!m_vld[p]) begin reason = 5; return; end
            if (m_vpn[p] == v) begin hit = 1; pfn = m_pfn[p]; reason = 0; return; end
            p = m_nxt[p];
        end
    endtask

    task automatic lookup(input int v, input bit hold);
        bit e_hit; int e_pfn; int e_steps; int reason; int n; bit got;
        string tag;
        bit h0; int p0;
        model(v, e_hit, e_pfn, e_steps, reason);
        tag = (reason == 0) ? "R3" : (reason == 4) ? "R4" : (reason == 5) ? "R5" : "R7";
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready before request", int'(req_ready), 1);
        req_vpn = VPN_W'(v); req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; got = 0;
        while (!got && n < 64) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rsp_valid) got = 1;
        end
        chk(got && n == e_steps, "R6", $sformatf("latency vpn %0d", v), n, e_steps);
        chk(rsp_hit == e_hit, tag, $sformatf("hit vpn %0d bucket R2 %0d", v, bucket_of(v)), int'(rsp_hit), int'(e_hit));
        chk(int'(rsp_pfn) == e_pfn, e_hit ? "R3" : "R10", $sformatf("pfn vpn %0d", v), int'(rsp_pfn), e_pfn);
        if (hold) begin
            h0 = rsp_hit; p0 = int'(rsp_pfn);
            @(posedge clk);
            @(negedge clk);
            chk(rsp_valid && rsp_hit == h0 && int'(rsp_pfn) == p0, "R8", "held response", int'(rsp_pfn), p0);
            chk(req_ready == 1'b0, "R8", "busy while response pending", int'(req_ready), 0);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R8", "idle after response taken", int'(req_ready), 1);
    endtask

    task automatic sweep();
        for (int v = 0; v < (1 << VPN_W); v++) lookup(v, (v % 16) == 3);
    endtask

    initial begin
        for (int i = 0; i < N_ENT; i++) begin
            m_vld[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_nxt[i] = 0;
        end
        for (int b = 0; b < N_BKT; b++) m_head[b] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "in reset", int'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "after reset", int'(rsp_valid), 0);

        // Empty table: every lookup misses on a null head (R1, R4).
        for (int v = 0; v < 16; v++) lookup(v * 17, 1'b0);

        // Build chains by head insertion (R2, R9).
        for (int k = 1; k <= 11; k++) insert(k, (k * 37 + 5) & 255, k + 20);
        // Duplicate of element 1 inserted ahead of it: first match wins (R3).
        insert(12, 42, 50);
        // Out-of-range bucket head write must be ignored (R9).
        put_head(7, 5);
        sweep();

        // Invalid element in front of a chain ends the walk (R5).
        begin
            int b2;
            b2 = bucket_of(79);
            put_elem(13, 1'b0, 79, 33, m_head[b2]);
            put_head(b2, 13);
            lookup(79, 1'b1);
        end

        // Write to slot 0 is ignored and a zero head reads as empty (R9, R4).
        put_elem(0, 1'b1, 8'h11, 9, 0);
        put_head(bucket_of(8'h11), 0);
        lookup(8'h11, 1'b0);

        // Self-looping chain terminates by the hop limit (R7).
        put_elem(15, 1'b1, 8'hFF, 44, 15);
        put_head(bucket_of(8'hFF), 15);
        lookup(8'h22, 1'b1);
        lookup(8'hFF, 1'b0);

        sweep();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule